// File: doc/BRIEF.md
# Bidirectional Cascaded Line Capture

This block fills one display line's worth of channel codes from a wide pixel bus. Every clock it takes six 8-bit codes, which are two RGB pixels, and hands them to an external line register as one six-channel group. A line holds 64 groups, which is 384 channels. The fill can run upward from channel 1 or downward from channel 384, depending on a direction input.

A start pulse on one of two bidirectional cascade pins begins the fill. After the 64th group is written, the block drives a one-clock carry pulse on the other pin. Several devices can be chained this way, each one starting when the one before it is full. Each pin is modelled as an input, an output and an output enable.

Two inversion controls complement the incoming codes bitwise, one for each half of the byte lanes. A bus can then be driven with inverted data to reduce switching. The line register itself is outside the block; the block only drives the register's write port.

Top module: `cascade_line_capture`

## Requirements
- R1: When `inv_lo` is 1, lanes 0 to 2 (bits [23:0] of `lane_data`) reach `wr_codes` bitwise complemented, for example 00→FF, 07→F8, 15→EA. When `inv_lo` is 0 they pass unchanged.
- R2: `inv_hi` acts on lanes 3 to 5 (bits [47:24]) in the same way. It is independent of `inv_lo`.
- R3: With `fill_up`=1 the start pulse is taken from `casc1_in`. The k-th capture after the start (k = 0..63) writes group index k. Group g holds channels 6g+1 to 6g+6. Lane j, at bits [8j+7:8j], goes to channel 6g+j+1 at the same bit position of `wr_codes`.
- R4: With `fill_up`=0 the start pulse is taken from `casc2_in`. The k-th capture writes group index 63−k. The lane order within a group is the same as in R3.
- R5: A start level that is high at a rising edge, after being low at the previous edge, starts a fill. `wr_en` is then high in exactly the 64 cycles after that edge. Each of those cycles presents the codes applied in that cycle.
- R6: In the cycle after the 64th write, the outgoing pin's output (`casc2_out` when `fill_up`=1, `casc1_out` when `fill_up`=0) and `done` are high for exactly one cycle, and `busy` is low.
- R7: A start level held high for many cycles, including past the end of the fill, starts exactly one fill.
- R8: A new start edge during a fill neither restarts nor extends it, and it does not cause a second fill afterwards.
- R9: `casc1_oe` = NOT `fill_up` and `casc2_oe` = `fill_up`, so the pin acting as input is never driven.
- R10: After reset and whenever idle, `busy`, `done`, `wr_en` and both cascade outputs are 0. No write reaches the line register while idle.
- R11: The cascade output on the incoming-side pin stays 0 throughout a fill and its carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_up | input | 1 | 1: fill from channel 1 upward; 0: fill from channel 384 downward |
| casc1_in | input | 1 | Cascade pin 1 input level |
| casc1_out | output | 1 | Cascade pin 1 driven value (carry when filling down) |
| casc1_oe | output | 1 | Cascade pin 1 output enable |
| casc2_in | input | 1 | Cascade pin 2 input level |
| casc2_out | output | 1 | Cascade pin 2 driven value (carry when filling up) |
| casc2_oe | output | 1 | Cascade pin 2 output enable |
| lane_data | input | 48 | Six 8-bit codes, lane j at bits [8j+7:8j] |
| inv_lo | input | 1 | Complement lanes 0 to 2 |
| inv_hi | input | 1 | Complement lanes 3 to 5 |
| wr_en | output | 1 | Line-register write strobe |
| wr_group | output | 6 | Group index written (group g = channels 6g+1 to 6g+6) |
| wr_codes | output | 48 | Codes after inversion, lane order preserved |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle pulse when the line is full |

## Verification
A wrong group pointer shows at `wr_group` in the same cycle as the faulty write. The scoreboard compares every write against its expected group and codes, so a pointer error is caught at once. A miscounted fill length shows up in one of two ways. Either a write arrives with nothing left to expect, or the carry pulse is not found in the single cycle after the 64th write. A stuck or re-armed start detector shows as `busy` or `wr_en` being high in the idle cycles that follow a fill, when the start level was held high or pulsed again during the fill.

// File: rtl/lcap_pkg.sv
package lcap_pkg;
    typedef enum logic {
        FILL_DOWN = 1'b0,
        FILL_UP   = 1'b1
    } fill_dir_e;
endpackage

// File: rtl/lcap_invert.sv
module lcap_invert #(
    parameter int LANES  = 6,
    parameter int CODE_W = 8
) (
    input  logic [LANES*CODE_W-1:0] raw_codes,
    input  logic                    inv_lo,
    input  logic                    inv_hi,
    output logic [LANES*CODE_W-1:0] out_codes
);
    localparam int HALF = LANES / 2;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic flip;
        if (j < HALF) begin : g_lo
            assign flip = inv_lo;
        end else begin : g_hi
            assign flip = inv_hi;
        end
        assign out_codes[j*CODE_W +: CODE_W] = raw_codes[j*CODE_W +: CODE_W] ^ {CODE_W{flip}};
    end
endmodule

// File: rtl/lcap_seq.sv
module lcap_seq
    import lcap_pkg::*;
#(
    parameter int GROUPS = 64,
    localparam int CNT_W = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_lvl,
    input  fill_dir_e        dir,
    output logic             busy_o,
    output logic [CNT_W-1:0] grp_o,
    output logic             carry_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUPS - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             prev;
        logic             carry;
    } seq_t;

    seq_t q, d;
    logic rise;

    always_comb begin
        d       = q;
        rise    = start_lvl & ~q.prev;
        d.prev  = start_lvl;
        d.carry = 1'b0;
        if (q.busy) begin
            if (q.cnt == LAST) begin
                d.busy  = 1'b0;
                d.cnt   = '0;
                d.carry = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (rise) begin
            d.busy = 1'b1;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = q.busy;
    assign carry_o = q.carry;
    assign grp_o   = (dir == FILL_UP) ? q.cnt : LAST - q.cnt;

    p_start_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && start_lvl && !q.prev) |=> (q.busy && q.cnt == '0));

    p_step_ignores_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != LAST) |=> (q.busy && q.cnt == CNT_W'($past(q.cnt) + 1'b1)));

    p_end_gives_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> q.carry);

    p_carry_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.carry |=> !q.carry);
endmodule

// File: rtl/cascade_line_capture.sv
module cascade_line_capture
    import lcap_pkg::*;
#(
    parameter int LANES  = 6,
    parameter int CODE_W = 8,
    parameter int GROUPS = 64,
    localparam int BUS_W = LANES * CODE_W,
    localparam int GRP_W = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_up,
    input  logic             casc1_in,
    output logic             casc1_out,
    output logic             casc1_oe,
    input  logic             casc2_in,
    output logic             casc2_out,
    output logic             casc2_oe,
    input  logic [BUS_W-1:0] lane_data,
    input  logic             inv_lo,
    input  logic             inv_hi,
    output logic             wr_en,
    output logic [GRP_W-1:0] wr_group,
    output logic [BUS_W-1:0] wr_codes,
    output logic             busy,
    output logic             done
);
    fill_dir_e dir;
    logic      start_lvl;
    logic      carry;

    assign dir       = fill_dir_e'(fill_up);
    assign start_lvl = (dir == FILL_UP) ? casc1_in : casc2_in;

    lcap_invert #(
        .LANES  (LANES),
        .CODE_W (CODE_W)
    ) u_invert (
        .raw_codes (lane_data),
        .inv_lo    (inv_lo),
        .inv_hi    (inv_hi),
        .out_codes (wr_codes)
    );

    lcap_seq #(
        .GROUPS (GROUPS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_lvl (start_lvl),
        .dir       (dir),
        .busy_o    (busy),
        .grp_o     (wr_group),
        .carry_o   (carry)
    );

    assign wr_en     = busy;
    assign done      = carry;
    assign casc1_oe  = (dir == FILL_DOWN);
    assign casc2_oe  = (dir == FILL_UP);
    assign casc1_out = carry & casc1_oe;
    assign casc2_out = carry & casc2_oe;

    p_no_carry_in_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !(casc1_out || casc2_out));

    p_quiet_input_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(casc1_out && casc2_out));
endmodule

// File: tb/cascade_line_capture_tb_top.sv
module cascade_line_capture_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_up = 1'b1;
    logic        casc1_in = 1'b0, casc2_in = 1'b0;
    logic        casc1_out, casc1_oe, casc2_out, casc2_oe;
    logic [47:0] lane_data = '0;
    logic        inv_lo = 1'b0, inv_hi = 1'b0;
    logic        wr_en, busy, done;
    logic [5:0]  wr_group;
    logic [47:0] wr_codes;

    int total = 0;
    int bad = 0;
    logic [53:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    cascade_line_capture dut_i (
        .clk(clk), .rst_n(rst_n), .fill_up(fill_up),
        .casc1_in(casc1_in), .casc1_out(casc1_out), .casc1_oe(casc1_oe),
        .casc2_in(casc2_in), .casc2_out(casc2_out), .casc2_oe(casc2_oe),
        .lane_data(lane_data), .inv_lo(inv_lo), .inv_hi(inv_hi),
        .wr_en(wr_en), .wr_group(wr_group), .wr_codes(wr_codes),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [47:0] expect_codes(input logic [47:0] raw, input bit lo, input bit hi);
        return raw ^ {{24{hi}}, {24{lo}}};
    endfunction

    task automatic set_start(input bit up, input logic v);
        if (up) casc1_in = v; else casc2_in = v;
    endtask

    // monitor: pops the scoreboard on every write
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && wr_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected write", {58'd0, wr_group}, 64'd0);
                end else begin
                    logic [53:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(wr_group == e[53:48], t, "group", {58'd0, wr_group}, {58'd0, e[53:48]});
                    check(wr_codes == e[47:0], t, "codes", {16'd0, wr_codes}, {16'd0, e[47:0]});
                end
            end
        end
    end

    task automatic idle_check(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lane_data = {$urandom, $urandom};
            #1;
            check(!busy && !wr_en && !done && !casc1_out && !casc2_out, req, "idle outputs",
                  {60'd0, busy, wr_en, casc1_out, casc2_out}, 64'd0);
        end
    endtask

    // start_len: cycles the start level stays high (>64 means past the end)
    task automatic run_line(input bit up, input int start_len, input bit restart_mid,
                            input bit lo, input bit hi, input bit fixed, input string tag);
        fill_up = up;
        inv_lo  = lo;
        inv_hi  = hi;
        @(negedge clk);
        set_start(up, 1'b1);
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            logic [47:0] raw;
            if (fixed) raw = 48'h15_07_00_15_07_00;
            else raw = {$urandom, $urandom};
            lane_data = raw;
            if (i + 1 == start_len) set_start(up, 1'b0);
            if (restart_mid && i == 20) set_start(up, 1'b1);
            if (restart_mid && i == 22) set_start(up, 1'b0);
            exp_q.push_back({up ? 6'(i) : 6'(63 - i), expect_codes(raw, lo, hi)});
            tag_q.push_back(tag);
            @(negedge clk);
        end
        #1;
        check((up ? casc2_out : casc1_out) && done && !busy && !wr_en, "R6", "carry cycle",
              {61'd0, casc2_out, casc1_out, done}, up ? 64'h5 : 64'h3);
        check(!(up ? casc1_out : casc2_out), "R11", "incoming pin quiet", 64'd0, 64'd0);
        check(exp_q.size() == 0, "R5", "writes outstanding", 64'(exp_q.size()), 64'd0);
        @(negedge clk);
        #1;
        check(!casc1_out && !casc2_out && !done, "R6", "carry one cycle",
              {62'd0, casc2_out, casc1_out}, 64'd0);
        if (start_len > 64) begin
            idle_check(4, "R7");
            set_start(up, 1'b0);
        end
        if (restart_mid) idle_check(4, "R8");
        idle_check(2, "R10");
    endtask

    initial begin
        #(CLK_P * 150000);
        check(1'b0, "R5", "watchdog expired", 64'd0, 64'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !wr_en && !done && !casc1_out && !casc2_out, "R10", "reset state",
              {61'd0, busy, wr_en, done}, 64'd0);
        rst_n = 1'b1;
        idle_check(3, "R10");

        fill_up = 1'b1; #1;
        check(!casc1_oe && casc2_oe, "R9", "oe up", {62'd0, casc1_oe, casc2_oe}, 64'h1);
        fill_up = 1'b0; #1;
        check(casc1_oe && !casc2_oe, "R9", "oe down", {62'd0, casc1_oe, casc2_oe}, 64'h2);

        run_line(1'b1, 1,  1'b0, 1'b1, 1'b0, 1'b1, "R1");
        run_line(1'b1, 1,  1'b0, 1'b0, 1'b1, 1'b1, "R2");
        run_line(1'b1, 2,  1'b0, 1'b0, 1'b0, 1'b0, "R3");
        run_line(1'b0, 1,  1'b0, 1'b1, 1'b1, 1'b0, "R4");
        run_line(1'b1, 70, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
        run_line(1'b0, 70, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        run_line(1'b1, 3,  1'b1, 1'b0, 1'b0, 1'b0, "R8");
        run_line(1'b0, 1,  1'b1, 1'b1, 1'b0, 1'b0, "R8");

        // start on the wrong pin for the direction: no fill
        fill_up = 1'b1;
        @(negedge clk);
        casc2_in = 1'b1;
        idle_check(3, "R3");
        casc2_in = 1'b0;
        fill_up = 1'b0;
        @(negedge clk);
        casc1_in = 1'b1;
        idle_check(3, "R4");
        casc1_in = 1'b0;
        idle_check(2, "R10");
        summary();
    end
endmodule